// File: doc/BRIEF.md
# Write-Allocate Region Filter

This block decides whether a pending write miss may allocate a line in the cache. Each request carries the write address and a set of override flags. The override flags come from allocate conditions that are evaluated elsewhere. The block compares the address against a programmable allocate ceiling, which is counted in 4 MB steps. It also applies a separate enable bit to a fixed 1 MB memory hole that spans 15 MB up to 16 MB. It returns one permit bit per request.

Requests enter through a valid/ready handshake. The decision is registered and appears one cycle after the request is accepted. It is held while the consumer stalls. A single write port loads the control word that holds the ceiling and the hole enable. Reset clears the control word, so nothing allocates until software programs a ceiling, unless an override is active.

Top module: `wa_region_filter`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the control word is all zeros. Every request with no override bit set is therefore denied.
- R2: When `cfg_we` is high at a clock edge, the control word is loaded from `cfg_wdata`. Bit 0 is the hole enable and bits [7:1] are the ceiling in 4 MB units. A request accepted at that same edge is still decided with the previous control word.
- R3: With a nonzero ceiling field L and no override, an address below L*4 MB is permitted and an address at or above L*4 MB is denied. The hole window is the exception, as described in R5 and R6.
- R4: A ceiling field of zero denies every request whose override bits are all zero.
- R5: When the ceiling field is at least 4 (16 MB) and the hole enable is 1, an address in [15 MB, 16 MB) is permitted.
- R6: When the ceiling field is at least 4 and the hole enable is 0, an address in [15 MB, 16 MB) is denied if no override bit is set.
- R7: When the ceiling field is 1 to 3, the hole enable has no effect: addresses in the window follow the ceiling rule and are denied.
- R8: If any bit of `req_ovr` is 1, the request is permitted regardless of address and control word.
- R9: A request is accepted when `req_valid` and `req_ready` are both high at an edge. Its decision appears on `rsp_allow` with `rsp_valid` high after that same edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, `rsp_valid` stays high and `rsp_allow` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit 0 hole enable, bits [7:1] ceiling in 4 MB units |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Write miss address in bytes |
| req_ovr | input | N_OVR | Override flags from other allocate conditions |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_allow | output | 1 | 1 = allocation permitted |

## Verification
The properties assume that `rst` is high for at least the first clock edge. They also assume that request inputs and the control strobe are driven to known values once reset is released. The stimulus holds reset for several cycles and changes every input only at the falling clock edge. Stalls are created by holding `rsp_ready` low while fresh requests wait on the input side. This exercises the hold and backpressure properties with request data that would give a different answer if it were taken early.

// File: rtl/wa_filter_pkg.sv
package wa_filter_pkg;

    localparam int LIMIT_W      = 7;
    localparam int CFG_W        = LIMIT_W + 1;
    localparam int UNIT_SHIFT   = 22;               // 4 MB ceiling granule
    localparam int MB_SHIFT     = 20;
    localparam int HOLE_LO_MB   = 15;
    localparam int HOLE_HI_MB   = 16;
    localparam int HOLE_ARM_MIN = HOLE_HI_MB >> (UNIT_SHIFT - MB_SHIFT);

    typedef struct packed {
        logic [LIMIT_W-1:0] limit;
        logic               hole_en;
    } wa_cfg_t;

    typedef struct packed {
        logic below_limit;
        logic in_window;
        logic hole_armed;
    } wa_region_t;

    function automatic wa_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        wa_cfg_t c;
        c.hole_en = w[0];
        c.limit   = w[CFG_W-1:1];
        return c;
    endfunction

    function automatic logic decide(input wa_region_t r, input logic hole_en,
                                    input logic ovr_any);
        logic base;
        if (r.in_window && r.hole_armed)
            base = hole_en;
        else
            base = r.below_limit;
        return base | ovr_any;
    endfunction

endpackage

// File: rtl/wa_cfg_reg.sv
module wa_cfg_reg
    import wa_filter_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output wa_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we)
            cfg <= unpack_cfg(wdata);
    end

endmodule

// File: rtl/wa_region_decode.sv
module wa_region_decode
    import wa_filter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  wa_cfg_t           cfg,
    output wa_region_t        region
);

    localparam int PAGE_W = ADDR_W - UNIT_SHIFT;
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(HOLE_LO_MB) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(HOLE_HI_MB) << MB_SHIFT;

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] lim_ext;

    assign page    = addr[ADDR_W-1:UNIT_SHIFT];
    assign lim_ext = PAGE_W'(cfg.limit);

    always_comb begin
        region.below_limit = (page < lim_ext);
        region.in_window   = (addr >= WIN_LO) && (addr < WIN_HI);
        region.hole_armed  = (cfg.limit >= LIMIT_W'(HOLE_ARM_MIN));
    end

endmodule

// File: rtl/wa_decide_stage.sv
module wa_decide_stage
    import wa_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  wa_region_t region,
    input  logic       hole_en,
    input  logic       ovr_any,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_allow
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_allow <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid)
                out_allow <= decide(region, hole_en, ovr_any);
        end
    end

endmodule

// File: rtl/wa_region_filter.sv
module wa_region_filter
    import wa_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_OVR  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [N_OVR-1:0]  req_ovr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_allow
);

    wa_cfg_t            cfg_q;
    wa_region_t         region;
    logic [LIMIT_W-1:0] cfg_limit_w;
    logic               cfg_hole_w;

    assign cfg_limit_w = cfg_q.limit;
    assign cfg_hole_w  = cfg_q.hole_en;

    wa_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    wa_region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (req_addr),
        .cfg    (cfg_q),
        .region (region)
    );

    wa_decide_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .region    (region),
        .hole_en   (cfg_hole_w),
        .ovr_any   (|req_ovr),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_allow (rsp_allow)
    );

endmodule

// File: rtl/wa_region_filter_chk.sv
module wa_region_filter_chk
    import wa_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_OVR  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [N_OVR-1:0]   req_ovr,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               rsp_allow,
    input logic [LIMIT_W-1:0] cfg_limit,
    input logic               cfg_hole
);

    localparam logic [ADDR_W-1:0] LO = ADDR_W'(HOLE_LO_MB) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(HOLE_HI_MB) << MB_SHIFT;

    logic fire, in_win, armed, no_ovr;
    assign fire   = req_valid && req_ready;
    assign in_win = (req_addr >= LO) && (req_addr < HI);
    assign armed  = cfg_limit >= LIMIT_W'(HOLE_ARM_MIN);
    assign no_ovr = (req_ovr == '0);

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !rsp_valid);

    a_r4_zero_limit: assert property (@(posedge clk) disable iff (rst)
        fire && cfg_limit == '0 && no_ovr |=> !rsp_allow);

    a_r5_hole_open: assert property (@(posedge clk) disable iff (rst)
        fire && in_win && armed && cfg_hole |=> rsp_allow);

    a_r6_hole_shut: assert property (@(posedge clk) disable iff (rst)
        fire && in_win && armed && !cfg_hole && no_ovr |=> !rsp_allow);

    a_r8_override: assert property (@(posedge clk) disable iff (rst)
        fire && !no_ovr |=> rsp_allow);

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    a_r10_block_in: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |-> !req_ready);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_allow));

endmodule

bind wa_region_filter wa_region_filter_chk #(.ADDR_W(ADDR_W), .N_OVR(N_OVR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_ovr   (req_ovr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_allow (rsp_allow),
    .cfg_limit (cfg_limit_w),
    .cfg_hole  (cfg_hole_w)
);

// File: tb/wa_region_filter_tb.sv
module wa_region_filter_tb_top;

    localparam int ADDR_W = 32;
    localparam int N_OVR  = 2;
    localparam longint MB = 64'd1 << 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [N_OVR-1:0]  req_ovr = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic              rsp_allow;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    wa_region_filter #(.ADDR_W(ADDR_W), .N_OVR(N_OVR)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_ovr(req_ovr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_allow(rsp_allow)
    );

    function automatic logic model(input longint addr, input int lim,
                                   input bit hole, input int ovr);
        longint ceil_b;
        bit below, win, armed;
        ceil_b = longint'(lim) * 4 * MB;
        below  = addr < ceil_b;
        win    = (addr >= 15 * MB) && (addr < 16 * MB);
        armed  = lim >= 4;
        if (ovr != 0) return 1'b1;
        if (win && armed) return hole;
        return below;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int lim, input bit hole);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {7'(lim), hole};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input logic [N_OVR-1:0] o,
                          input logic exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_ovr   = o;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 valid"}, rsp_valid, 1'b1);
        check(tag, rsp_allow, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint addrs[12];
        int     lims[8];
        addrs = '{0, 4*MB-1, 4*MB, 8*MB-1, 15*MB-1, 15*MB, 15*MB + MB/2,
                  16*MB-1, 16*MB, 20*MB-1, 20*MB, 64'hFFFF_FFFF};
        lims  = '{0, 1, 2, 3, 4, 5, 63, 127};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid", rsp_valid, 1'b0);
        check("R1 req_ready", req_ready, 1'b1);
        do_req(32'h0, 2'b00, 1'b0, "R1 cleared cfg denies");
        do_req(32'h0, 2'b10, 1'b1, "R8 override after reset");

        // R2: config write lands after a request accepted on the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {7'd4, 1'b0};
        req_valid = 1'b1; req_addr = 32'h100; req_ovr = '0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R2 old cfg used", rsp_allow, 1'b0);
        do_req(32'h100, 2'b00, 1'b1, "R2 new cfg used");

        // Sweep: R3 R4 R5 R6 R7 R8
        foreach (lims[li]) begin
            for (int h = 0; h < 2; h++) begin
                write_cfg(lims[li], h[0]);
                for (int o = 0; o < 4; o++) begin
                    foreach (addrs[ai]) begin
                        string tag;
                        bit win;
                        win = (addrs[ai] >= 15*MB) && (addrs[ai] < 16*MB);
                        if (o != 0)               tag = "R8 override";
                        else if (lims[li] == 0)   tag = "R4 zero ceiling";
                        else if (win && lims[li] >= 4) tag = h ? "R5 hole open" : "R6 hole shut";
                        else if (win)             tag = "R7 hole ignored";
                        else                      tag = "R3 ceiling";
                        do_req(addrs[ai][ADDR_W-1:0], o[N_OVR-1:0],
                               model(addrs[ai], lims[li], h[0], o), tag);
                    end
                end
            end
        end

        // R10: backpressure holds decision and blocks input
        write_cfg(4, 1'b0);
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'h10; req_ovr = '0;   // permit
        @(negedge clk);
        req_addr = 32'(15*MB);                                 // would deny
        check("R10 valid held", rsp_valid, 1'b1);
        check("R10 ready low", req_ready, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 allow held", rsp_allow, 1'b1);
        check("R10 still blocked", req_ready, 1'b0);
        rsp_ready = 1'b1;
        #1;
        check("R10 ready on release", req_ready, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 next decision", rsp_allow, 1'b0);
        @(negedge clk);
        check("R9 idle drops valid", rsp_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule